// File: doc/BRIEF.md
# Privileged Address Segment Decoder

This block sorts each 32-bit virtual address into one of five fixed windows and chooses how it reaches memory. The choice depends on the window and on the current privilege level (user, supervisor or kernel). Two kernel-only windows are unmapped: the block forms the physical address by subtracting the window base. The low half of the space and the two upper windows are translated by a lookup structure beside this block. For those, the block passes on the lookup's physical address and write permission. An access that the privilege level does not allow becomes an address error.

The lookup must answer in the same cycle as the request. The block turns every failure into a 5-bit exception code, using the direction of the access. It marks a lookup miss with a refill flag, because a miss is handled differently from an entry that is present but invalid. An error-level input overrides translation of the low half of the space: while it is set, that region maps one-to-one with read and write allowed. All results leave through one register stage, so they appear one clock after the request. A parameter can remove that stage.

Top module: `vaddr_seg_decoder`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, out_valid, out_fault, out_refill and out_mapped are 0, and out_paddr, out_prot and out_code are 0.
- R2: With the default register stage, out_valid equals the req_valid of the previous cycle. When out_valid is 0, every other output is 0.
- R3: An address with bit 31 clear and req_errlvl=1 gives out_paddr = req_vaddr, out_prot = 2'b11 (bit 0 read, bit 1 write) and no fault, in every mode. With req_errlvl=0 the same address takes the translated route.
- R4: In kernel mode, addresses 0x80000000–0x9FFFFFFF give out_paddr = vaddr − 0x80000000 and out_prot = 2'b11. In the other modes they raise an address error.
- R5: In kernel mode, addresses 0xA0000000–0xBFFFFFFF give out_paddr = vaddr − 0xA0000000 and out_prot = 2'b11. In the other modes they raise an address error.
- R6: Addresses 0xC0000000–0xDFFFFFFF take the translated route in supervisor and kernel mode, and raise an address error in user mode.
- R7: Addresses 0xE0000000–0xFFFFFFFF take the translated route in kernel mode only. In user and supervisor mode they raise an address error.
- R8: The req_priv encoding is 0 = kernel, 1 = supervisor, 2 = user. Code 3 is neither user nor supervisor, so it behaves as kernel.
- R9: An address error sets out_fault with out_code 5 for a write (req_write=1) and 4 for a read. It leaves out_paddr and out_prot at 0, and out_mapped and out_refill at 0.
- R10: The tlb_res encoding is 0 = hit, 1 = no match, 2 = invalid, 3 = write to a clean entry. On a translated route with a hit, out_paddr = tlb_paddr, out_prot = {tlb_wr_ok, 1}, out_mapped = 1 and there is no fault.
- R11: On a translated route, no match or invalid gives code 3 for a write and 2 for a read. A write to a clean entry gives code 1 whatever the direction. Every such fault leaves out_paddr and out_prot at 0.
- R12: out_refill is 1 only for a translated route whose result is no match, and out_mapped is 1 exactly when the translated route was taken.
- R13: On an unmapped or address-error route, tlb_res, tlb_paddr and tlb_wr_ok have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_priv | input | 2 | Privilege level: 0 kernel, 1 supervisor, 2 user, 3 kernel |
| req_errlvl | input | 1 | Error-level override of the low region |
| req_write | input | 1 | 1 = store access, 0 = load access |
| tlb_res | input | 2 | Lookup result for req_vaddr: 0 hit, 1 no match, 2 invalid, 3 clean on write |
| tlb_paddr | input | 32 | Physical address from the lookup on a hit |
| tlb_wr_ok | input | 1 | Lookup entry permits writes |
| out_valid | output | 1 | Result present |
| out_paddr | output | 32 | Physical address (0 on fault) |
| out_prot | output | 2 | Permission: bit 0 read, bit 1 write |
| out_fault | output | 1 | Access raises an exception |
| out_code | output | 5 | Exception code: 0 none, 1 modify, 2/3 lookup load/store, 4/5 address load/store |
| out_refill | output | 1 | Fault came from a lookup miss |
| out_mapped | output | 1 | Translated route was taken |

## Verification
The bench probes each window boundary (0x7FFFFFFF/0x80000000, 0x9FFFFFFF/0xA0000000, 0xBFFFFFFF/0xC0000000, 0xDFFFFFFF/0xE0000000) under every privilege code. A decoder that slices the address one bit off would route a boundary address to the neighbouring window and produce the wrong base or a wrong fault. Privilege code 3 is driven on its own: a design that treats only code 0 as kernel would raise address errors there. The error-level flag is set together with addresses in the upper windows, to catch a design that lets it leak past the low region. Changing the lookup inputs on unmapped routes, and driving a clean-entry result on both reads and writes, shows up a design that lets the lookup reach the subtractive path or picks the modify code by direction.

// File: rtl/segdec_pkg.sv
package segdec_pkg;
   typedef enum logic [1:0] {
      PRIV_KERN = 2'd0,
      PRIV_SUPV = 2'd1,
      PRIV_USER = 2'd2,
      PRIV_KALT = 2'd3
   } priv_e;

   typedef enum logic [1:0] {
      LKP_HIT    = 2'd0,
      LKP_MISS   = 2'd1,
      LKP_INVAL  = 2'd2,
      LKP_CLEAN  = 2'd3
   } lkp_e;

   typedef enum logic [2:0] {
      RT_XLATE = 3'd0,
      RT_IDENT = 3'd1,
      RT_SUBLO = 3'd2,
      RT_SUBHI = 3'd3,
      RT_ADERR = 3'd4
   } route_e;

   localparam int EXC_NONE   = 0;
   localparam int EXC_MODIFY = 1;
   localparam int EXC_LKP_LD = 2;
   localparam int EXC_LKP_ST = 3;
   localparam int EXC_ADR_LD = 4;
   localparam int EXC_ADR_ST = 5;
endpackage

// File: rtl/segdec_classify.sv
module segdec_classify
   import segdec_pkg::*;
(
   input  logic [2:0] seg_top,
   input  logic [1:0] priv,
   input  logic       errlvl,
   output route_e     route
);
   logic is_kern;
   logic is_supv;

   always_comb begin
      is_supv = (priv == PRIV_SUPV);
      is_kern = (priv != PRIV_SUPV) && (priv != PRIV_USER);
   end

   always_comb begin
      route = RT_ADERR;
      if (!seg_top[2]) begin
         route = errlvl ? RT_IDENT : RT_XLATE;
      end else begin
         unique case (seg_top[1:0])
            2'b00:   route = is_kern ? RT_SUBLO : RT_ADERR;
            2'b01:   route = is_kern ? RT_SUBHI : RT_ADERR;
            2'b10:   route = (is_kern || is_supv) ? RT_XLATE : RT_ADERR;
            default: route = is_kern ? RT_XLATE : RT_ADERR;
         endcase
      end
   end
endmodule

// File: rtl/segdec_resolve.sv
module segdec_resolve
   import segdec_pkg::*;
#(
   parameter int AW = 32,
   parameter int EW = 5
) (
   input  route_e          route,
   input  logic [AW-1:0]   vaddr,
   input  logic            write,
   input  logic [1:0]      lkp_res,
   input  logic [AW-1:0]   lkp_paddr,
   input  logic            lkp_wr_ok,
   output logic [AW-1:0]   paddr,
   output logic [1:0]      prot,
   output logic            fault,
   output logic [EW-1:0]   code,
   output logic            refill,
   output logic            mapped
);
   localparam logic [AW-1:0] LO_BASE = {3'b100, {(AW-3){1'b0}}};
   localparam logic [AW-1:0] HI_BASE = {3'b101, {(AW-3){1'b0}}};
   localparam logic [EW-1:0] C_MOD   = EW'(EXC_MODIFY);
   localparam logic [EW-1:0] C_LLD   = EW'(EXC_LKP_LD);
   localparam logic [EW-1:0] C_LST   = EW'(EXC_LKP_ST);
   localparam logic [EW-1:0] C_ALD   = EW'(EXC_ADR_LD);
   localparam logic [EW-1:0] C_AST   = EW'(EXC_ADR_ST);

   always_comb begin
      paddr  = '0;
      prot   = 2'b00;
      fault  = 1'b0;
      code   = EW'(EXC_NONE);
      refill = 1'b0;
      mapped = 1'b0;
      unique case (route)
         RT_IDENT: begin
            paddr = vaddr;
            prot  = 2'b11;
         end
         RT_SUBLO: begin
            paddr = vaddr - LO_BASE;
            prot  = 2'b11;
         end
         RT_SUBHI: begin
            paddr = vaddr - HI_BASE;
            prot  = 2'b11;
         end
         RT_ADERR: begin
            fault = 1'b1;
            code  = write ? C_AST : C_ALD;
         end
         default: begin
            mapped = 1'b1;
            unique case (lkp_res)
               LKP_HIT: begin
                  paddr = lkp_paddr;
                  prot  = {lkp_wr_ok, 1'b1};
               end
               LKP_MISS: begin
                  fault  = 1'b1;
                  refill = 1'b1;
                  code   = write ? C_LST : C_LLD;
               end
               LKP_INVAL: begin
                  fault = 1'b1;
                  code  = write ? C_LST : C_LLD;
               end
               default: begin
                  fault = 1'b1;
                  code  = C_MOD;
               end
            endcase
         end
      endcase
   end
endmodule

// File: rtl/segdec_outstage.sv
module segdec_outstage #(
   parameter int W       = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/vaddr_seg_decoder.sv
module vaddr_seg_decoder
   import segdec_pkg::*;
#(
   parameter int AW      = 32,
   parameter int EW      = 5,
   parameter bit REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [AW-1:0] req_vaddr,
   input  logic [1:0]    req_priv,
   input  logic          req_errlvl,
   input  logic          req_write,
   input  logic [1:0]    tlb_res,
   input  logic [AW-1:0] tlb_paddr,
   input  logic          tlb_wr_ok,
   output logic          out_valid,
   output logic [AW-1:0] out_paddr,
   output logic [1:0]    out_prot,
   output logic          out_fault,
   output logic [EW-1:0] out_code,
   output logic          out_refill,
   output logic          out_mapped
);
   localparam int BW = 1 + AW + 2 + 1 + EW + 1 + 1;

   generate
      if (AW < 4) begin : g_bad_aw
         $error("vaddr_seg_decoder: AW must be at least 4");
      end
      if (EW < 3) begin : g_bad_ew
         $error("vaddr_seg_decoder: EW must hold code 5");
      end
   endgenerate

   route_e          route;
   logic [AW-1:0]   c_paddr;
   logic [1:0]      c_prot;
   logic            c_fault;
   logic [EW-1:0]   c_code;
   logic            c_refill;
   logic            c_mapped;
   logic [BW-1:0]   bundle_d;
   logic [BW-1:0]   bundle_q;

   segdec_classify u_cls (
      .seg_top (req_vaddr[AW-1 -: 3]),
      .priv    (req_priv),
      .errlvl  (req_errlvl),
      .route   (route)
   );

   segdec_resolve #(.AW(AW), .EW(EW)) u_res (
      .route     (route),
      .vaddr     (req_vaddr),
      .write     (req_write),
      .lkp_res   (tlb_res),
      .lkp_paddr (tlb_paddr),
      .lkp_wr_ok (tlb_wr_ok),
      .paddr     (c_paddr),
      .prot      (c_prot),
      .fault     (c_fault),
      .code      (c_code),
      .refill    (c_refill),
      .mapped    (c_mapped)
   );

   assign bundle_d = req_valid
                   ? {1'b1, c_paddr, c_prot, c_fault, c_code, c_refill, c_mapped}
                   : '0;

   segdec_outstage #(.W(BW), .REG_OUT(REG_OUT)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bundle_d),
      .q     (bundle_q)
   );

   assign {out_valid, out_paddr, out_prot, out_fault,
           out_code, out_refill, out_mapped} = bundle_q;
endmodule

// File: rtl/segdec_chk.sv
module segdec_chk
   import segdec_pkg::*;
#(
   parameter int AW      = 32,
   parameter int EW      = 5,
   parameter bit REG_OUT = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic [AW-1:0] req_vaddr,
   input logic [1:0]    req_priv,
   input logic          req_errlvl,
   input logic          req_write,
   input logic [1:0]    tlb_res,
   input logic          out_valid,
   input logic [AW-1:0] out_paddr,
   input logic [1:0]    out_prot,
   input logic          out_fault,
   input logic [EW-1:0] out_code,
   input logic          out_refill,
   input logic          out_mapped
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!out_fault && !out_refill && !out_mapped && out_prot == 2'b00)); // R2
   AST_FAULT_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
      out_fault |-> (out_prot == 2'b00 && out_paddr == '0 && out_code != '0)); // R9
   AST_REFILL_ONLY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      out_refill |-> (out_fault && out_mapped &&
                      (out_code == EW'(EXC_LKP_LD) || out_code == EW'(EXC_LKP_ST)))); // R12

   generate
      if (REG_OUT) begin : g_seq
         AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid |=> out_valid); // R2
         AST_LOWREG_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && !req_vaddr[AW-1] && req_errlvl) |=>
            (!out_fault && out_prot == 2'b11 && out_paddr == $past(req_vaddr))); // R3
         AST_USER_HIGH_ADERR: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_vaddr[AW-1] && req_priv == PRIV_USER) |=>
            (out_fault && !out_mapped &&
             out_code == ($past(req_write) ? EW'(EXC_ADR_ST) : EW'(EXC_ADR_LD)))); // R9
         AST_HIWIN_BASE: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_vaddr[AW-1 -: 3] == 3'b101 && req_priv == PRIV_KERN) |=>
            (!out_fault && out_paddr[AW-1 -: 3] == 3'b000)); // R5
         AST_CLEAN_MODIFY: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && !req_vaddr[AW-1] && !req_errlvl && tlb_res == LKP_CLEAN) |=>
            (out_fault && out_code == EW'(EXC_MODIFY))); // R11
      end
   endgenerate
endmodule

bind vaddr_seg_decoder segdec_chk #(.AW(AW), .EW(EW), .REG_OUT(REG_OUT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_vaddr  (req_vaddr),
   .req_priv   (req_priv),
   .req_errlvl (req_errlvl),
   .req_write  (req_write),
   .tlb_res    (tlb_res),
   .out_valid  (out_valid),
   .out_paddr  (out_paddr),
   .out_prot   (out_prot),
   .out_fault  (out_fault),
   .out_code   (out_code),
   .out_refill (out_refill),
   .out_mapped (out_mapped)
);

// File: tb/sim_vaddr_seg_decoder.sv
`timescale 1ns/1ps
module sim_vaddr_seg_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_priv = '0;
   logic        req_errlvl = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  tlb_res = '0;
   logic [31:0] tlb_paddr = '0;
   logic        tlb_wr_ok = 1'b0;
   logic        out_valid;
   logic [31:0] out_paddr;
   logic [1:0]  out_prot;
   logic        out_fault;
   logic [4:0]  out_code;
   logic        out_refill;
   logic        out_mapped;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   vaddr_seg_decoder u0 (.*);

   // expected values
   logic [31:0] e_paddr;
   logic [1:0]  e_prot;
   logic        e_fault;
   logic [4:0]  e_code;
   logic        e_refill;
   logic        e_mapped;
   string       e_tag;

   function automatic bit f_kern(input logic [1:0] p);
      return (p == 2'd0) || (p == 2'd3);
   endfunction

   task automatic model();
      int  kind; // 0 ident 1 sub 2 xlate 3 aderr
      logic [31:0] base;
      base = 32'h0;
      e_paddr = '0; e_prot = '0; e_fault = 0; e_code = 0; e_refill = 0; e_mapped = 0;
      if (req_vaddr < 32'h8000_0000) begin
         kind = req_errlvl ? 0 : 2;
         e_tag = req_errlvl ? "R3" : "R10";
      end else if (req_vaddr < 32'hA000_0000) begin
         kind = f_kern(req_priv) ? 1 : 3; base = 32'h8000_0000; e_tag = "R4";
      end else if (req_vaddr < 32'hC000_0000) begin
         kind = f_kern(req_priv) ? 1 : 3; base = 32'hA000_0000; e_tag = "R5";
      end else if (req_vaddr < 32'hE000_0000) begin
         kind = (req_priv != 2'd2) ? 2 : 3; e_tag = "R6";
      end else begin
         kind = f_kern(req_priv) ? 2 : 3; e_tag = "R7";
      end
      if (req_priv == 2'd3) e_tag = "R8";
      case (kind)
         0: begin e_paddr = req_vaddr; e_prot = 2'b11; end
         1: begin e_paddr = req_vaddr - base; e_prot = 2'b11; end
         3: begin e_fault = 1; e_code = req_write ? 5'd5 : 5'd4; e_tag = "R9"; end
         default: begin
            e_mapped = 1;
            case (tlb_res)
               2'd0: begin e_paddr = tlb_paddr; e_prot = {tlb_wr_ok, 1'b1}; end
               2'd1: begin e_fault = 1; e_refill = 1; e_code = req_write ? 5'd3 : 5'd2; e_tag = "R12"; end
               2'd2: begin e_fault = 1; e_code = req_write ? 5'd3 : 5'd2; e_tag = "R11"; end
               default: begin e_fault = 1; e_code = 5'd1; e_tag = "R11"; end
            endcase
         end
      endcase
   endtask

   task automatic check_out(input string tag, input logic ev);
      checks++;
      if (out_valid !== ev || out_paddr !== e_paddr || out_prot !== e_prot ||
          out_fault !== e_fault || out_code !== e_code ||
          out_refill !== e_refill || out_mapped !== e_mapped) begin
         fails++;
         $display("FAIL %s va=%h: got v%0b pa=%h pr=%b f%0b c%0d rf%0b m%0b exp v%0b pa=%h pr=%b f%0b c%0d rf%0b m%0b",
                  tag, req_vaddr, out_valid, out_paddr, out_prot, out_fault, out_code,
                  out_refill, out_mapped, ev, e_paddr, e_prot, e_fault, e_code,
                  e_refill, e_mapped);
      end
   endtask

   // drive one request at posedge+1, check at next posedge+1
   task automatic one(input logic [31:0] va, input logic [1:0] pr, input logic el,
                      input logic wr, input logic [1:0] tr, input logic [31:0] tp,
                      input logic tw, input string tag);
      string t;
      req_valid = 1; req_vaddr = va; req_priv = pr; req_errlvl = el;
      req_write = wr; tlb_res = tr; tlb_paddr = tp; tlb_wr_ok = tw;
      model();
      t = (tag == "") ? e_tag : tag;
      @(posedge clk); #1;
      check_out(t, 1'b1);
   endtask

   task automatic idle();
      req_valid = 0;
      req_vaddr = $urandom; req_errlvl = 1'b1; tlb_res = 2'd1;
      e_paddr = '0; e_prot = '0; e_fault = 0; e_code = 0; e_refill = 0; e_mapped = 0;
      @(posedge clk); #1;
      check_out("R2", 1'b0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         fails++;
         $display("FAIL watchdog: got cycle %0d exp below 100000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   logic [31:0] bnd [10] = '{32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'h9FFF_FFFF,
                             32'hA000_0000, 32'hBFFF_FFFF, 32'hC000_0000, 32'hDFFF_FFFF,
                             32'hE000_0000, 32'hFFFF_FFFF};

   initial begin
      void'($urandom(32'd1234));
      e_paddr = '0; e_prot = '0; e_fault = 0; e_code = 0; e_refill = 0; e_mapped = 0;
      #12;
      check_out("R1", 1'b0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check_out("R1", 1'b0);

      // boundaries under every privilege code, both directions
      for (int b = 0; b < 10; b++)
         for (int p = 0; p < 4; p++)
            for (int w = 0; w < 2; w++)
               one(bnd[b], 2'(p), 1'b0, 1'(w), 2'd0, 32'h1234_5000, 1'b1, "");

      // error level: low region identity, upper windows unaffected
      one(32'h7FFF_FFFF, 2'd2, 1'b1, 1'b1, 2'd1, 32'h0, 1'b0, "R3");
      one(32'h0000_0040, 2'd1, 1'b1, 1'b0, 2'd3, 32'h0, 1'b0, "R3");
      one(32'h8000_1000, 2'd2, 1'b1, 1'b0, 2'd0, 32'h0, 1'b1, "R3");
      one(32'hA000_1000, 2'd0, 1'b1, 1'b0, 2'd1, 32'h0, 1'b1, "R5");

      // mode 3 acts as kernel
      one(32'h9234_5678, 2'd3, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, "R8");
      one(32'hF000_0010, 2'd3, 1'b0, 1'b1, 2'd0, 32'hCAFE_0000, 1'b0, "R8");

      // lookup results on the translated route
      one(32'h0040_0000, 2'd2, 1'b0, 1'b0, 2'd0, 32'h0ABC_D000, 1'b0, "R10");
      one(32'h0040_0000, 2'd2, 1'b0, 1'b1, 2'd0, 32'h0ABC_D000, 1'b1, "R10");
      one(32'h0040_0000, 2'd2, 1'b0, 1'b0, 2'd1, 32'h0, 1'b0, "R12");
      one(32'h0040_0000, 2'd2, 1'b0, 1'b1, 2'd2, 32'h0, 1'b0, "R11");
      one(32'hC100_0000, 2'd1, 1'b0, 1'b0, 2'd3, 32'h0, 1'b0, "R11");
      one(32'hC100_0000, 2'd1, 1'b0, 1'b1, 2'd3, 32'h0, 1'b0, "R11");

      // lookup inputs ignored on unmapped and error routes
      for (int t = 0; t < 4; t++) begin
         one(32'h8765_4321, 2'd0, 1'b0, 1'b1, 2'(t), $urandom, 1'(t), "R13");
         one(32'hB765_4321, 2'd0, 1'b0, 1'b0, 2'(t), $urandom, 1'(t), "R13");
         one(32'hE765_4321, 2'd1, 1'b0, 1'b1, 2'(t), $urandom, 1'(t), "R13");
      end

      idle();
      idle();

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         if (($urandom % 16) == 0) idle();
         else one($urandom, 2'($urandom), 1'(($urandom % 4) == 0), 1'($urandom),
                  2'($urandom), $urandom, 1'($urandom), "");
      end
      idle();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule